// File: doc/BRIEF.md
# Capped Row-Hit Request Arbiter

This block chooses which pending request a memory channel controller should issue next. Each of the N candidate slots has a valid bit and a write flag. Slots that hold reads also carry a group-priority mark, a thread priority level, a bank number, a flag saying the request targets the open row, and an arrival stamp. The block compares the slots pairwise in a balanced tree and reports the winning slot index together with a valid flag.

Favouring open-row requests raises throughput, but it can starve other work. The block therefore keeps a streak counter for each bank. The counter grows on every issued row hit and drops back to one on every issued miss. When a bank's streak reaches a programmable cap, open-row requests to that bank stop getting any preference. Issue is signalled by a one-cycle strobe, and the counter update applies to the slot that is winning in that cycle.

Top module: `capped_hit_arbiter`

## Requirements
- R1: A slot whose valid bit is 0 never wins. `valid_out` is 1 exactly when at least one slot is valid.
- R2: A valid write (`cand_write` bit = 1) beats any valid read.
- R3: Between two reads, when exactly one has its mark bit set, the marked read wins.
- R4: Between two reads with equal mark bits and different priority levels, the read with the numerically larger `cand_rank` wins.
- R5: Between two reads that tie on mark and level, an effective row hit beats a non-hit.
- R6: Any remaining tie between two reads goes to the smaller arrival stamp. When the stamps are equal, the lower slot index wins.
- R7: When `issue_i` is high and `valid_out` is 1 at a clock edge, the winning slot's bank counter is incremented (saturating) if that slot's raw hit flag is 1, and is set to 1 otherwise. Counters of other banks do not change.
- R8: A slot's hit flag counts as 0 while its bank counter is greater than or equal to `cap_i`. A cap of 0 therefore turns off the row-hit preference entirely.
- R9: Between two writes, the smaller arrival stamp wins. When the stamps are equal, the lower slot index wins.
- R10: Reset clears every bank counter to 0, so after reset a row hit is preferred whenever `cap_i` is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_i | input | CAP_W | Streak cap; 0 disables hit preference |
| cand_valid | input | N | Slot holds a request |
| cand_write | input | N | Slot request is a write |
| cand_mark | input | N | Group-priority mark per slot |
| cand_rank | input | N*RANK_W | Thread priority level per slot, larger is better |
| cand_bank | input | N*BANK_W | Target bank per slot |
| cand_hit | input | N | Slot request targets the open row |
| cand_ts | input | N*TS_W | Arrival stamp per slot, smaller is older |
| issue_i | input | 1 | Strobe: the current winner is being issued |
| valid_out | output | 1 | Some slot is valid |
| win_idx | output | IDX_W | Index of the winning slot |

## Verification
The streak counters cannot be read directly, so any error in them can only appear as a wrong winner. A counter that fails to advance keeps favouring hits for one issue too many. A counter that fails to reset keeps hits suppressed when they should win. Either fault changes `win_idx` in the same cycle that follows the faulty strobe, provided a hit and an older miss are competing for that bank. The tests are built around that situation. They step a bank up to the cap, issue a miss to another bank to confirm that bank's counter is unaffected, and then issue a miss to the capped bank to show the preference returning.

// File: rtl/capped_hit_arbiter.sv
module capped_hit_arbiter #(
  parameter int N      = 4,
  parameter int RANK_W = 3,
  parameter int BANK_W = 2,
  parameter int TS_W   = 8,
  parameter int CAP_W  = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CAP_W-1:0]    cap_i,
  input  logic [N-1:0]        cand_valid,
  input  logic [N-1:0]        cand_write,
  input  logic [N-1:0]        cand_mark,
  input  logic [N*RANK_W-1:0] cand_rank,
  input  logic [N*BANK_W-1:0] cand_bank,
  input  logic [N-1:0]        cand_hit,
  input  logic [N*TS_W-1:0]   cand_ts,
  input  logic                issue_i,
  output logic                valid_out,
  output logic [IDX_W-1:0]    win_idx
);
  localparam int LV  = (N > 1) ? $clog2(N) : 1;
  localparam int NP  = 1 << LV;
  localparam int NB  = 1 << BANK_W;
  localparam logic [CAP_W-1:0] SMAX = '1;

  logic [RANK_W-1:0] rk [N];
  logic [BANK_W-1:0] bk [N];
  logic [TS_W-1:0]   ts [N];
  logic [N-1:0]      hit_eff;
  logic [CAP_W-1:0]  streak [NB];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign rk[i] = cand_rank[i*RANK_W +: RANK_W];
    assign bk[i] = cand_bank[i*BANK_W +: BANK_W];
    assign ts[i] = cand_ts[i*TS_W +: TS_W];
    assign hit_eff[i] = cand_hit[i] && (streak[bk[i]] < cap_i);
  end

  function automatic logic a_wins(input logic wa, wb, ma, mb,
                                  input logic [RANK_W-1:0] ra, rb,
                                  input logic ha, hb,
                                  input logic [TS_W-1:0] ta, tb);
    if (wa != wb) return wa;
    if (wa)       return ta <= tb;
    if (ma != mb) return ma;
    if (ra != rb) return ra > rb;
    if (ha != hb) return ha;
    return ta <= tb;
  endfunction

  logic [IDX_W-1:0] nidx [1:2*NP-1];
  logic             nval [1:2*NP-1];

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      nidx[NP+k] = (k < N) ? IDX_W'(k) : '0;
      nval[NP+k] = (k < N) ? cand_valid[k] : 1'b0;
    end
    for (int k = NP-1; k >= 1; k--) begin
      logic [IDX_W-1:0] a, b;
      a = nidx[2*k];
      b = nidx[2*k+1];
      nval[k] = nval[2*k] | nval[2*k+1];
      if (nval[2*k] && (!nval[2*k+1] ||
          a_wins(cand_write[a], cand_write[b], cand_mark[a], cand_mark[b],
                 rk[a], rk[b], hit_eff[a], hit_eff[b], ts[a], ts[b])))
        nidx[k] = a;
      else
        nidx[k] = b;
    end
  end

  assign valid_out = nval[1];
  assign win_idx   = nidx[1];

  logic [BANK_W-1:0] win_bank;
  logic [CAP_W-1:0]  win_streak;
  logic              do_issue;
  assign win_bank   = bk[win_idx];
  assign win_streak = streak[win_bank];
  assign do_issue   = issue_i && valid_out;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        streak[b] <= '0;
      else if (do_issue && win_bank == BANK_W'(b))
        streak[b] <= cand_hit[win_idx] ? ((streak[b] == SMAX) ? SMAX : streak[b] + 1'b1)
                                       : CAP_W'(1);
    end
  end

  p_win_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> cand_valid[win_idx]);
  p_none_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (cand_valid == '0));
  p_write_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && !cand_write[win_idx]) |-> ((cand_valid & cand_write) == '0));
  p_mark_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && !cand_write[win_idx] && !cand_mark[win_idx])
      |-> ((cand_valid & cand_mark) == '0));
  p_hit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_issue && cand_hit[win_idx] && win_streak != SMAX)
      |=> streak[$past(win_bank)] == $past(win_streak) + CAP_W'(1));
  p_miss_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_issue && !cand_hit[win_idx]) |=> streak[$past(win_bank)] == CAP_W'(1));
endmodule

// File: tb/sim_capped_hit_arbiter.sv
module sim_capped_hit_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, RANK_W = 3, BANK_W = 2, TS_W = 8, CAP_W = 4;

  logic clk = 0, rst_n = 0, issue_i = 0;
  logic [CAP_W-1:0]    cap_i = 2;
  logic [N-1:0]        cand_valid = 0, cand_write = 0, cand_mark = 0, cand_hit = 0;
  logic [N*RANK_W-1:0] cand_rank = 0;
  logic [N*BANK_W-1:0] cand_bank = 0;
  logic [N*TS_W-1:0]   cand_ts = 0;
  logic valid_out;
  logic [1:0] win_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capped_hit_arbiter #(.N(N), .RANK_W(RANK_W), .BANK_W(BANK_W), .TS_W(TS_W), .CAP_W(CAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .cand_valid(cand_valid), .cand_write(cand_write),
    .cand_mark(cand_mark), .cand_rank(cand_rank), .cand_bank(cand_bank), .cand_hit(cand_hit),
    .cand_ts(cand_ts), .issue_i(issue_i), .valid_out(valid_out), .win_idx(win_idx));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    cand_valid = 0; cand_write = 0; cand_mark = 0; cand_hit = 0;
    cand_rank = 0; cand_bank = 0; cand_ts = 0;
  endtask

  task automatic put(input int i, input bit w, input bit m, input int r,
                     input int b, input bit h, input int t);
    cand_valid[i] = 1; cand_write[i] = w; cand_mark[i] = m; cand_hit[i] = h;
    cand_rank[i*RANK_W +: RANK_W] = RANK_W'(r);
    cand_bank[i*BANK_W +: BANK_W] = BANK_W'(b);
    cand_ts[i*TS_W +: TS_W] = TS_W'(t);
  endtask

  task automatic expect_win(input string req, input int idx);
    #1;
    check(req, int'(valid_out), 1);
    check(req, int'(win_idx), idx);
  endtask

  task automatic strobe();
    @(negedge clk); issue_i = 1;
    @(posedge clk); #1 issue_i = 0;
  endtask

  task automatic t_reset();
    clear(); #1;
    check("R1 idle", int'(valid_out), 0);
    cap_i = 2;
    put(0, 0, 0, 0, 0, 0, 1); put(1, 0, 0, 0, 0, 1, 5);
    expect_win("R10", 1);
  endtask

  task automatic t_invalid();
    clear(); put(3, 0, 0, 0, 0, 0, 200);
    cand_mark[0] = 1; cand_hit[0] = 1; cand_write[1] = 1;
    expect_win("R1", 3);
  endtask

  task automatic t_write();
    clear(); put(0, 0, 1, 7, 0, 1, 0); put(2, 1, 0, 0, 3, 0, 250);
    expect_win("R2", 2);
  endtask

  task automatic t_two_writes();
    clear(); put(1, 1, 0, 0, 0, 0, 9); put(3, 1, 1, 7, 0, 1, 4);
    expect_win("R9 older", 3);
    put(3, 1, 1, 7, 0, 1, 9);
    expect_win("R9 tie", 1);
  endtask

  task automatic t_mark();
    clear(); put(0, 0, 0, 7, 0, 1, 0); put(2, 0, 1, 0, 0, 0, 90);
    expect_win("R3", 2);
  endtask

  task automatic t_rank();
    clear(); put(1, 0, 0, 2, 0, 1, 0); put(3, 0, 0, 5, 0, 0, 50);
    expect_win("R4", 3);
  endtask

  task automatic t_hit();
    clear(); put(0, 0, 0, 3, 0, 0, 1); put(2, 0, 0, 3, 2, 1, 9);
    expect_win("R5", 2);
  endtask

  task automatic t_age();
    clear(); put(1, 0, 0, 1, 0, 0, 7); put(2, 0, 0, 1, 0, 0, 3);
    expect_win("R6 older", 2);
    put(2, 0, 0, 1, 0, 0, 7);
    expect_win("R6 tie", 1);
  endtask

  task automatic t_cap();
    cap_i = 2;
    clear(); put(0, 0, 0, 0, 1, 1, 20); put(1, 0, 0, 0, 2, 0, 10);
    expect_win("R8 below cap", 0);
    strobe();
    expect_win("R7 streak 1", 0);
    strobe();
    expect_win("R8 at cap", 1);
    strobe();
    expect_win("R7 other bank untouched", 1);
    clear(); put(0, 0, 0, 0, 1, 0, 20);
    strobe();
    clear(); put(0, 0, 0, 0, 1, 1, 20); put(1, 0, 0, 0, 2, 0, 10);
    expect_win("R7 miss resets to 1", 0);
    cap_i = 0;
    expect_win("R8 cap zero", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_invalid();
    t_write();
    t_two_writes();
    t_mark();
    t_rank();
    t_hit();
    t_age();
    t_cap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule